// File: doc/BRIEF.md
# Converter Output Word Formatter with Built-in Pattern Source

This block is the last digital stage of one converter channel before its output pins. On every sample clock it takes an 8-bit offset-binary sample, shifts it by a small signed trim with clamping at the code limits, and recodes it into the data format that the board expects. It can also complement the final word, and it can force the outputs to a quiet state. One instance is placed per channel, so each channel has its own trim.

For board bring-up and link checking, a 3-bit pattern selector replaces the converter data with a generated source. The sources are fixed codes, a two-word toggle, a bit checkerboard, and two pseudorandom sequences. Each sequence generator can be reseeded through its own clear input. Fixed codes and the toggle word pass through the format recoder. The checkerboard and the pseudorandom words go straight to the output.

Top module: `cos_top`

## Requirements
- R1: While `rst_n` is low, `dout` is 0x00 and `dout_vld` is 0. Both generators hold an all-ones state, and the toggle phase is cleared.
- R2: With the pattern selector at 000, the word presented on one rising edge appears on `dout` after that edge. `dout_vld` carries the `smp_vld` captured on the same edge.
- R3: With the pattern selector at 000, `trim` is read as a 4-bit two's-complement number from -8 to +7 and added to the sample. The sum clamps to 0x00 below zero and to 0xFF above 255, and never wraps.
- R4: `fmt_sel` selects the output code. 00 is offset binary, 01 is two's complement (the offset-binary MSB inverted), and 10 is Gray code (b XOR (b >> 1)). The reserved value 11 behaves as 00.
- R5: When `inv_en` is high, every bit of the final word is complemented. This applies to every source, including the patterns that bypass format conversion.
- R6: When `out_en` is low on an edge, `dout` becomes 0x00 and `dout_vld` becomes 0 after that edge, whatever the other inputs are.
- R7: With any non-zero pattern selector, `smp_in`, `smp_vld` and `trim` have no effect on `dout`, and `dout_vld` is 1 on every enabled cycle.
- R8: Selector 001 gives 0x80, 010 gives 0xFF and 011 gives 0x00. Selector 111 alternates 0xFF and 0x00. All of these codes are offset-binary values that then pass through the format recoder.
- R9: Selector 100 alternates 0x55 and 0xAA and bypasses the format recoder. The toggle phase is a single flop that is cleared by reset and flips on every clock, in every mode. The first clock after reset gives 0x55 for selector 100 and 0xFF for selector 111.
- R10: The short generator runs x^9+x^5+1 as a left shift with feedback of state bits 8 and 4. It advances once per clock in every mode. Selector 110 outputs state bits 8..1, unformatted. While `pn9_clr` is high on an edge, the state is reloaded with all ones instead of advancing.
- R11: The long generator runs x^23+x^18+1 with feedback of state bits 22 and 17. It advances once per clock in every mode. Selector 101 outputs state bits 22..15, unformatted. `pn23_clr` reloads it with all ones.
- R12: Each clear input acts only on its own generator. Asserting `pn23_clr` leaves the short sequence unbroken, and asserting `pn9_clr` leaves the long sequence unbroken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 8 | Converter sample, offset binary |
| smp_vld | input | 1 | Sample strobe |
| fmt_sel | input | 2 | Output code select |
| inv_en | input | 1 | Complement the final word |
| out_en | input | 1 | Output enable; low forces zero and not-valid |
| trim | input | 4 | Signed offset trim |
| pat_sel | input | 3 | Pattern selector, 000 selects converter data |
| pn23_clr | input | 1 | Reseed the long generator |
| pn9_clr | input | 1 | Reseed the short generator |
| dout | output | 8 | Formatted output word |
| dout_vld | output | 1 | Output word valid |

## Verification
The bench pushes samples near both code limits together with the extreme trims -8 and +7. A formatter that wrapped instead of clamping would send 0x02 to 0xFA or similar, far from the clamped value. It checks every format code against each kind of source, so a design that recoded the checkerboard or PN words, or that treated code 11 as Gray, would show mismatches. It also holds one generator's clear while the other sequence is on the output, which exposes shared or swapped clear wiring as a broken sequence. Finally, it changes modes in the middle of a run, which catches a toggle flop or generator that only runs while it is selected.

// File: rtl/cos_pkg.sv
package cos_pkg;
   typedef enum logic [1:0] {
      FMT_OFFBIN = 2'b00,
      FMT_TWOS   = 2'b01,
      FMT_GRAY   = 2'b10,
      FMT_RSVD   = 2'b11
   } fmt_e;

   typedef enum logic [2:0] {
      PAT_NONE  = 3'b000,
      PAT_MID   = 3'b001,
      PAT_PFS   = 3'b010,
      PAT_NFS   = 3'b011,
      PAT_CHK   = 3'b100,
      PAT_PNL   = 3'b101,
      PAT_PNS   = 3'b110,
      PAT_WTGL  = 3'b111
   } pat_e;
endpackage

// File: rtl/cos_lfsr.sv
module cos_lfsr #(
   parameter int W   = 9,
   parameter int TAP = 5,
   parameter int OW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [OW-1:0] word
);
   if (TAP < 1 || TAP >= W) begin : g_bad_tap
      $error("cos_lfsr: TAP must lie in 1..W-1");
   end
   if (OW > W) begin : g_bad_ow
      $error("cos_lfsr: OW must not exceed W");
   end

   logic [W-1:0] st_q;
   logic         fb;

   assign fb = st_q[W-1] ^ st_q[TAP-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= '1;
      else if (clr) st_q <= '1;
      else          st_q <= {st_q[W-2:0], fb};
   end

   assign word = st_q[W-1 -: OW];
endmodule

// File: rtl/cos_trim_sat.sv
module cos_trim_sat #(
   parameter int DW = 8,
   parameter int TW = 4
) (
   input  logic [DW-1:0] smp,
   input  logic [TW-1:0] ofs,
   output logic [DW-1:0] res
);
   localparam int SW = DW + 2;

   if (TW > DW + 1) begin : g_bad_tw
      $error("cos_trim_sat: trim wider than sum headroom");
   end

   logic [SW-1:0] ext_s;
   logic [SW-1:0] ext_t;
   logic [SW-1:0] sum;

   assign ext_s = {2'b00, smp};
   assign ext_t = {{(SW-TW){ofs[TW-1]}}, ofs};
   assign sum   = ext_s + ext_t;

   always_comb begin
      if (sum[SW-1])      res = '0;
      else if (sum[DW])   res = '1;
      else                res = sum[DW-1:0];
   end
endmodule

// File: rtl/cos_code_map.sv
module cos_code_map
   import cos_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [1:0]    mode,
   input  logic [DW-1:0] ob,
   output logic [DW-1:0] cw
);
   fmt_e          sel;
   logic [DW-1:0] gray_w;

   assign sel = fmt_e'(mode);

   for (genvar i = 0; i < DW; i++) begin : g_gray
      if (i == DW-1) begin : g_top
         assign gray_w[i] = ob[i];
      end else begin : g_low
         assign gray_w[i] = ob[i] ^ ob[i+1];
      end
   end

   always_comb begin
      case (sel)
         FMT_TWOS: cw = {~ob[DW-1], ob[DW-2:0]};
         FMT_GRAY: cw = gray_w;
         default:  cw = ob;
      endcase
   end
endmodule

// File: rtl/cos_top.sv
module cos_top
   import cos_pkg::*;
#(
   parameter int DW      = 8,
   parameter int TW      = 4,
   parameter int PNL_W   = 23,
   parameter int PNL_TAP = 18,
   parameter int PNS_W   = 9,
   parameter int PNS_TAP = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] smp_in,
   input  logic          smp_vld,
   input  logic [1:0]    fmt_sel,
   input  logic          inv_en,
   input  logic          out_en,
   input  logic [TW-1:0] trim,
   input  logic [2:0]    pat_sel,
   input  logic          pn23_clr,
   input  logic          pn9_clr,
   output logic [DW-1:0] dout,
   output logic          dout_vld
);
   localparam logic [DW-1:0] MID_CODE = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] ONES     = {DW{1'b1}};

   if (DW < 2) begin : g_bad_dw
      $error("cos_top: DW must be at least 2");
   end
   if (PNL_W < DW || PNS_W < DW) begin : g_bad_pn
      $error("cos_top: generator state narrower than output word");
   end

   pat_e          pat;
   logic          tgl_q;
   logic [DW-1:0] chk_a;
   logic [DW-1:0] trimmed;
   logic [DW-1:0] pnl_w;
   logic [DW-1:0] pns_w;
   logic [DW-1:0] raw_w;
   logic          use_fmt;
   logic [DW-1:0] coded_w;
   logic [DW-1:0] pick_w;
   logic [DW-1:0] final_w;

   assign pat = pat_e'(pat_sel);

   for (genvar i = 0; i < DW; i++) begin : g_chk
      assign chk_a[i] = ((i % 2) == 0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgl_q <= 1'b0;
      else        tgl_q <= ~tgl_q;
   end

   cos_trim_sat #(.DW(DW), .TW(TW)) u_trim (
      .smp (smp_in),
      .ofs (trim),
      .res (trimmed)
   );

   cos_lfsr #(.W(PNL_W), .TAP(PNL_TAP), .OW(DW)) u_pnl (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pn23_clr),
      .word  (pnl_w)
   );

   cos_lfsr #(.W(PNS_W), .TAP(PNS_TAP), .OW(DW)) u_pns (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pn9_clr),
      .word  (pns_w)
   );

   always_comb begin
      use_fmt = 1'b1;
      case (pat)
         PAT_MID:  raw_w = MID_CODE;
         PAT_PFS:  raw_w = ONES;
         PAT_NFS:  raw_w = '0;
         PAT_WTGL: raw_w = tgl_q ? '0 : ONES;
         PAT_CHK: begin
            raw_w   = tgl_q ? ~chk_a : chk_a;
            use_fmt = 1'b0;
         end
         PAT_PNL: begin
            raw_w   = pnl_w;
            use_fmt = 1'b0;
         end
         PAT_PNS: begin
            raw_w   = pns_w;
            use_fmt = 1'b0;
         end
         default:  raw_w = trimmed;
      endcase
   end

   cos_code_map #(.DW(DW)) u_map (
      .mode (fmt_sel),
      .ob   (raw_w),
      .cw   (coded_w)
   );

   assign pick_w  = use_fmt ? coded_w : raw_w;
   assign final_w = pick_w ^ {DW{inv_en}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout     <= '0;
         dout_vld <= 1'b0;
      end else begin
         dout     <= out_en ? final_w : '0;
         dout_vld <= out_en & ((pat != PAT_NONE) | smp_vld);
      end
   end
endmodule

// File: rtl/cos_checker.sv
module cos_checker #(
   parameter int DW = 8,
   parameter int TW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] smp_in,
   input logic          smp_vld,
   input logic [1:0]    fmt_sel,
   input logic          inv_en,
   input logic          out_en,
   input logic [TW-1:0] trim,
   input logic [2:0]    pat_sel,
   input logic          pn9_clr,
   input logic [DW-1:0] dout,
   input logic          dout_vld
);
   // R6
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> (dout == '0 && !dout_vld));

   // R7
   pat_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && pat_sel != 3'b000) |=> dout_vld);

   // R2
   pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && pat_sel == 3'b000 && fmt_sel == 2'b00 && !inv_en && trim == '0)
      |=> (dout == $past(smp_in) && dout_vld == $past(smp_vld)));

   // R9
   checker_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && pat_sel == 3'b100 && !inv_en)
      |=> (&(dout[DW-1:1] ^ dout[DW-2:0])));

   // R10
   pns_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pn9_clr) && pat_sel == 3'b110 && out_en && !inv_en)
      |=> (dout == {DW{1'b1}}));

   // R8
   midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && pat_sel == 3'b001 && fmt_sel == 2'b00 && !inv_en)
      |=> (dout == {1'b1, {(DW-1){1'b0}}}));
endmodule

bind cos_top cos_checker #(.DW(DW), .TW(TW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_in   (smp_in),
   .smp_vld  (smp_vld),
   .fmt_sel  (fmt_sel),
   .inv_en   (inv_en),
   .out_en   (out_en),
   .trim     (trim),
   .pat_sel  (pat_sel),
   .pn9_clr  (pn9_clr),
   .dout     (dout),
   .dout_vld (dout_vld)
);

// File: tb/cos_top_tb.sv
module cos_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] smp_in = 8'h00;
   logic       smp_vld = 1'b0;
   logic [1:0] fmt_sel = 2'b00;
   logic       inv_en = 1'b0;
   logic       out_en = 1'b1;
   logic [3:0] trim = 4'h0;
   logic [2:0] pat_sel = 3'b000;
   logic       pn23_clr = 1'b0;
   logic       pn9_clr = 1'b0;
   logic [7:0] dout;
   logic       dout_vld;

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   int exp_d = 0;
   int exp_v = 0;
   int m_p9 = 'h1FF;
   int m_p23 = 'h7FFFFF;
   int m_tg = 0;
   int samp_mode = 0;

   always #4 clk = ~clk;

   cos_top u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_in   (smp_in),
      .smp_vld  (smp_vld),
      .fmt_sel  (fmt_sel),
      .inv_en   (inv_en),
      .out_en   (out_en),
      .trim     (trim),
      .pat_sel  (pat_sel),
      .pn23_clr (pn23_clr),
      .pn9_clr  (pn9_clr),
      .dout     (dout),
      .dout_vld (dout_vld)
   );

   function automatic int recode(int v, int f);
      if (f == 1) return v ^ 128;
      if (f == 2) return v ^ (v >> 1);
      return v;
   endfunction

   // behavioural reference, advanced once per rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_d = 0; exp_v = 0;
         m_p9 = 'h1FF; m_p23 = 'h7FFFFF; m_tg = 0;
      end else begin
         int w;
         int t;
         int fbs;
         int fbl;
         case (int'(pat_sel))
            0: begin
               t = int'(trim);
               if (t > 7) t = t - 16;
               w = int'(smp_in) + t;
               if (w < 0) w = 0;
               if (w > 255) w = 255;
               w = recode(w, int'(fmt_sel));
            end
            1: w = recode(128, int'(fmt_sel));
            2: w = recode(255, int'(fmt_sel));
            3: w = recode(0, int'(fmt_sel));
            4: w = (m_tg != 0) ? 'hAA : 'h55;
            5: w = (m_p23 >> 15) & 'hFF;
            6: w = (m_p9 >> 1) & 'hFF;
            default: w = recode((m_tg != 0) ? 0 : 255, int'(fmt_sel));
         endcase
         if (inv_en) w = w ^ 'hFF;
         exp_d = out_en ? w : 0;
         exp_v = (out_en && (pat_sel != 3'b000 || smp_vld)) ? 1 : 0;
         m_tg = 1 - m_tg;
         fbs = ((m_p9 >> 8) ^ (m_p9 >> 4)) & 1;
         fbl = ((m_p23 >> 22) ^ (m_p23 >> 17)) & 1;
         m_p9  = pn9_clr  ? 'h1FF    : (((m_p9 << 1) | fbs) & 'h1FF);
         m_p23 = pn23_clr ? 'h7FFFFF : (((m_p23 << 1) | fbl) & 'h7FFFFF);
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         n_chk++;
         if (dout !== exp_d[7:0] || dout_vld !== exp_v[0]) begin
            n_fail++;
            $display("FAIL %s dout=%h expected=%h vld=%b expected_vld=%0d",
                     cur_req, dout, exp_d[7:0], dout_vld, exp_v);
         end
      end
   end

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_vld = ($urandom_range(0, 3) != 0);
         if (samp_mode == 1)
            smp_in = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 15))
                                                 : 8'($urandom_range(240, 255));
         else
            smp_in = 8'($urandom_range(0, 255));
         if (samp_mode == 1) trim = 4'($urandom_range(0, 15));
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL %s watchdog actual=timeout expected=completion", cur_req);
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state observed while reset is held
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: first words after reset give the phase origin
      cur_req = "R9"; pat_sel = 3'b100; run(4);
      cur_req = "R2"; pat_sel = 3'b000; run(200);

      cur_req = "R3"; samp_mode = 1; run(300);
      trim = 4'h8; samp_mode = 0;
      @(negedge clk); smp_in = 8'h03;
      @(negedge clk); smp_in = 8'h08;
      @(negedge clk); trim = 4'h7; smp_in = 8'hFA;
      @(negedge clk); smp_in = 8'hF8;
      @(negedge clk); trim = 4'h0;

      cur_req = "R4";
      for (int f = 0; f < 4; f++) begin
         fmt_sel = 2'(f);
         run(60);
      end

      cur_req = "R5"; inv_en = 1'b1;
      for (int p = 0; p < 8; p++) begin
         pat_sel = 3'(p);
         run(20);
      end
      inv_en = 1'b0;

      cur_req = "R6"; out_en = 1'b0;
      for (int p = 0; p < 8; p++) begin
         pat_sel = 3'(p);
         inv_en = p[0];
         run(6);
      end
      out_en = 1'b1; inv_en = 1'b0;

      cur_req = "R7"; samp_mode = 1;
      for (int p = 1; p < 8; p++) begin
         pat_sel = 3'(p);
         run(10);
      end
      samp_mode = 0;

      cur_req = "R8";
      for (int f = 0; f < 4; f++) begin
         fmt_sel = 2'(f);
         for (int p = 1; p < 4; p++) begin
            pat_sel = 3'(p);
            run(5);
         end
         pat_sel = 3'b111; run(7);
      end

      cur_req = "R9"; pat_sel = 3'b100;
      for (int f = 0; f < 4; f++) begin
         fmt_sel = 2'(f);
         run(9);
      end
      fmt_sel = 2'b00;

      cur_req = "R10"; pat_sel = 3'b110; run(600);
      @(negedge clk); pn9_clr = 1'b1;
      @(negedge clk); @(negedge clk); pn9_clr = 1'b0;
      run(40);
      fmt_sel = 2'b10; run(20); fmt_sel = 2'b00;

      cur_req = "R11"; pat_sel = 3'b101; run(800);
      @(negedge clk); pn23_clr = 1'b1;
      @(negedge clk); pn23_clr = 1'b0;
      run(60);

      cur_req = "R12"; pat_sel = 3'b110;
      @(negedge clk); pn23_clr = 1'b1;
      run(15);
      @(negedge clk); pn23_clr = 1'b0;
      pat_sel = 3'b101;
      @(negedge clk); pn9_clr = 1'b1;
      run(15);
      @(negedge clk); pn9_clr = 1'b0;
      pat_sel = 3'b110; run(30);
      pat_sel = 3'b000; run(10);

      // R1: reset asserted again mid-run
      cur_req = "R1";
      @(negedge clk); rst_n = 1'b0;
      run(3);
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule